// File: doc/BRIEF.md
# USB Device Address and Bus-State Controller

This block holds the control state of a USB device controller that sits between firmware and the serial engine. It keeps the device address and its separate enable bit, and it decides which address the token decoder must accept. It also watches the line-idle indication from the transceiver. From that it raises a suspend event after a programmable span of continuous bus inactivity, and a wake-up event whenever activity resumes. Finally, it drives the soft-connect pull-up onto D+ or D- according to the detach and speed-select bits.

Firmware reaches the block through one write port. A two-bit selector picks the address register, the control register, the interrupt-enable register or the flag-clear register. The usual enumeration sequence is in three steps. Firmware records the new address while the enable is still clear. The zero-length status stage then completes against address 0. Only after that does firmware set the enable in a separate write. A suspend event also drops the controller out of high-speed mode. Firmware leaves suspend by clearing the freeze-clock bit, typically after a wake-up interrupt.

Top module: `usb_addr_bus_ctrl`

## Requirements
- R1: After reset, dev_addr_o is 0, the address enable is clear, both flags, irq_o, freeze_clk_o, hs_mode_o and addr_match_o are 0, and detach is 1, so both pull-up outputs are 0.
- R2: Selector 0 writes the stored address from wr_data_i. Bit 0 of a selector-1 write is the address enable. dev_addr_o equals the stored address while the enable is set, and 0 while it is clear.
- R3: A cycle with bus_reset_i high clears both the stored address and the enable. A cycle with macro_en_i low clears only the enable.
- R4: addr_match_o is high for exactly one cycle, in the cycle after a token_valid_i pulse whose token_addr_i equals dev_addr_o at that pulse.
- R5: susp_flag_o is set after IDLE_CYCLES (CLK_MHZ*IDLE_US) consecutive cycles with line_idle_i high, and not earlier. It is set once per idle span, and any cycle with line_idle_i low restarts the count.
- R6: hs_grant_i sets hs_mode_o. The suspend event clears hs_mode_o.
- R7: wake_flag_o is set in the cycle after line_idle_i goes from high to low, whether or not a suspend event occurred.
- R8: The suspend event clears a pending wake flag, and the wake event clears a pending suspend flag, so the two flags are never both set.
- R9: A selector-3 write clears the suspend flag where bit 0 is 1 and the wake flag where bit 1 is 1. An event in the same cycle as the clear wins.
- R10: Selector-2 bits 0 and 1 enable suspend and wake. irq_o is (suspend flag AND its enable) OR (wake flag AND its enable).
- R11: Control bit 2 is detach and bit 3 selects low speed. While detach is 0, pullup_dp_o is driven at full speed and pullup_dm_o at low speed. While detach is 1, both are 0.
- R12: Control bit 1 is the freeze-clock bit, presented on freeze_clk_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Power-up reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Register select: 0 address, 1 control, 2 enables, 3 flag clear |
| wr_data_i | input | ADDR_W | Write data |
| bus_reset_i | input | 1 | USB bus reset detected |
| macro_en_i | input | 1 | Controller enable |
| line_idle_i | input | 1 | Data lines in idle state |
| hs_grant_i | input | 1 | Pulse: high-speed handshake succeeded |
| token_valid_i | input | 1 | Pulse: decoded token present |
| token_addr_i | input | ADDR_W | Address field of the token |
| susp_flag_o | output | 1 | Suspend interrupt flag |
| wake_flag_o | output | 1 | Wake-up interrupt flag |
| irq_o | output | 1 | Interrupt request |
| dev_addr_o | output | ADDR_W | Effective device address |
| addr_match_o | output | 1 | Token address matched |
| freeze_clk_o | output | 1 | Freeze-clock control bit |
| hs_mode_o | output | 1 | High-speed mode active |
| pullup_dp_o | output | 1 | Enable the D+ pull-up |
| pullup_dm_o | output | 1 | Enable the D- pull-up |

## Verification
Some properties are checked on every cycle: the two flags are never set together, and the pull-ups never both drive. A request always implies a set flag, and a match always follows a token pulse. Each flag rises only after the matching line state, and the address reads zero after a bus reset or a disable. Only the scenarios can show the exact idle count at which suspend fires. They also show the single event per idle span, the restart on short activity, and an event beating a same-cycle clear. The ordering of address write and enable, and the low-speed pull-up choice, are likewise shown there.

// File: rtl/usbab_pkg.sv
package usbab_pkg;
    typedef enum logic [1:0] {
        SEL_ADDR = 2'd0,
        SEL_CTRL = 2'd1,
        SEL_IEN  = 2'd2,
        SEL_ICLR = 2'd3
    } reg_sel_e;

    localparam int CTRL_ADDR_EN = 0;
    localparam int CTRL_FREEZE  = 1;
    localparam int CTRL_DETACH  = 2;
    localparam int CTRL_LOWSPD  = 3;

    localparam int FLAG_SUSP = 0;
    localparam int FLAG_WAKE = 1;
endpackage

// File: rtl/usbab_idle_timer.sv
module usbab_idle_timer #(
    parameter int IDLE_CYCLES = 750000
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic line_idle_i,
    output logic susp_evt_o,
    output logic wake_evt_o
);
    localparam int CNT_W = $clog2(IDLE_CYCLES);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(IDLE_CYCLES - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             fired;
        logic             prev_idle;
    } tmr_t;

    tmr_t q, d;

    always_comb begin
        d            = q;
        d.prev_idle  = line_idle_i;
        susp_evt_o   = 1'b0;
        wake_evt_o   = ~line_idle_i & q.prev_idle;
        if (!line_idle_i) begin
            d.cnt   = '0;
            d.fired = 1'b0;
        end else if (!q.fired) begin
            if (q.cnt == LAST) begin
                susp_evt_o = 1'b1;
                d.fired    = 1'b1;
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end
endmodule

// File: rtl/usbab_addr_unit.sv
module usbab_addr_unit #(
    parameter int ADDR_W = 7
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_addr_i,
    input  logic              wr_ctrl_i,
    input  logic [ADDR_W-1:0] wr_data_i,
    input  logic              bus_reset_i,
    input  logic              macro_en_i,
    input  logic              token_valid_i,
    input  logic [ADDR_W-1:0] token_addr_i,
    output logic [ADDR_W-1:0] dev_addr_o,
    output logic              match_o
);
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              en;
        logic              match;
    } adr_t;

    adr_t q, d;
    logic [ADDR_W-1:0] eff;

    always_comb begin
        eff = q.en ? q.addr : '0;
        d   = q;
        if (wr_addr_i) d.addr = wr_data_i;
        if (wr_ctrl_i) d.en   = wr_data_i[usbab_pkg::CTRL_ADDR_EN];
        if (bus_reset_i) begin
            d.addr = '0;
            d.en   = 1'b0;
        end
        if (!macro_en_i) d.en = 1'b0;
        d.match = token_valid_i & (token_addr_i == eff);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    assign dev_addr_o = eff;
    assign match_o    = q.match;
endmodule

// File: rtl/usbab_evt_flags.sv
module usbab_evt_flags (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       wr_ien_i,
    input  logic       wr_iclr_i,
    input  logic [1:0] wr_bits_i,
    input  logic       susp_evt_i,
    input  logic       wake_evt_i,
    output logic       susp_o,
    output logic       wake_o,
    output logic       irq_o
);
    import usbab_pkg::*;

    typedef struct packed {
        logic susp;
        logic wake;
        logic susp_en;
        logic wake_en;
    } flg_t;

    flg_t q, d;

    always_comb begin
        d = q;
        if (wr_ien_i) begin
            d.susp_en = wr_bits_i[FLAG_SUSP];
            d.wake_en = wr_bits_i[FLAG_WAKE];
        end
        if (wr_iclr_i) begin
            if (wr_bits_i[FLAG_SUSP]) d.susp = 1'b0;
            if (wr_bits_i[FLAG_WAKE]) d.wake = 1'b0;
        end
        if (susp_evt_i) begin
            d.susp = 1'b1;
            d.wake = 1'b0;
        end
        if (wake_evt_i) begin
            d.wake = 1'b1;
            d.susp = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    assign susp_o = q.susp;
    assign wake_o = q.wake;
    assign irq_o  = (q.susp & q.susp_en) | (q.wake & q.wake_en);
endmodule

// File: rtl/usb_addr_bus_ctrl.sv
module usb_addr_bus_ctrl #(
    parameter int ADDR_W  = 7,
    parameter int CLK_MHZ = 250,
    parameter int IDLE_US = 3000
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic [1:0]        wr_sel_i,
    input  logic [ADDR_W-1:0] wr_data_i,
    input  logic              bus_reset_i,
    input  logic              macro_en_i,
    input  logic              line_idle_i,
    input  logic              hs_grant_i,
    input  logic              token_valid_i,
    input  logic [ADDR_W-1:0] token_addr_i,
    output logic              susp_flag_o,
    output logic              wake_flag_o,
    output logic              irq_o,
    output logic [ADDR_W-1:0] dev_addr_o,
    output logic              addr_match_o,
    output logic              freeze_clk_o,
    output logic              hs_mode_o,
    output logic              pullup_dp_o,
    output logic              pullup_dm_o
);
    import usbab_pkg::*;

    localparam int IDLE_CYCLES = CLK_MHZ * IDLE_US;

    typedef struct packed {
        logic freeze;
        logic detach;
        logic lowspd;
        logic hs;
    } ctl_t;

    ctl_t     q, d;
    reg_sel_e sel;
    logic     wr_addr, wr_ctrl, wr_ien, wr_iclr;
    logic     susp_evt, wake_evt;

    assign sel     = reg_sel_e'(wr_sel_i);
    assign wr_addr = wr_en_i && (sel == SEL_ADDR);
    assign wr_ctrl = wr_en_i && (sel == SEL_CTRL);
    assign wr_ien  = wr_en_i && (sel == SEL_IEN);
    assign wr_iclr = wr_en_i && (sel == SEL_ICLR);

    usbab_idle_timer #(.IDLE_CYCLES(IDLE_CYCLES)) u_timer (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .line_idle_i (line_idle_i),
        .susp_evt_o  (susp_evt),
        .wake_evt_o  (wake_evt)
    );

    usbab_addr_unit #(.ADDR_W(ADDR_W)) u_addr (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .wr_addr_i     (wr_addr),
        .wr_ctrl_i     (wr_ctrl),
        .wr_data_i     (wr_data_i),
        .bus_reset_i   (bus_reset_i),
        .macro_en_i    (macro_en_i),
        .token_valid_i (token_valid_i),
        .token_addr_i  (token_addr_i),
        .dev_addr_o    (dev_addr_o),
        .match_o       (addr_match_o)
    );

    usbab_evt_flags u_flags (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .wr_ien_i   (wr_ien),
        .wr_iclr_i  (wr_iclr),
        .wr_bits_i  (wr_data_i[1:0]),
        .susp_evt_i (susp_evt),
        .wake_evt_i (wake_evt),
        .susp_o     (susp_flag_o),
        .wake_o     (wake_flag_o),
        .irq_o      (irq_o)
    );

    always_comb begin
        d = q;
        if (wr_ctrl) begin
            d.freeze = wr_data_i[CTRL_FREEZE];
            d.detach = wr_data_i[CTRL_DETACH];
            d.lowspd = wr_data_i[CTRL_LOWSPD];
        end
        if (hs_grant_i) d.hs = 1'b1;
        if (susp_evt)   d.hs = 1'b0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '{freeze: 1'b0, detach: 1'b1, lowspd: 1'b0, hs: 1'b0};
        else         q <= d;
    end

    assign freeze_clk_o = q.freeze;
    assign hs_mode_o    = q.hs;
    assign pullup_dp_o  = ~q.detach & ~q.lowspd;
    assign pullup_dm_o  = ~q.detach &  q.lowspd;
endmodule

// File: rtl/usbab_chk.sv
module usbab_chk #(
    parameter int ADDR_W = 7
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              bus_reset_i,
    input logic              macro_en_i,
    input logic              line_idle_i,
    input logic              token_valid_i,
    input logic [ADDR_W-1:0] dev_addr_o,
    input logic              addr_match_o,
    input logic              susp_flag_o,
    input logic              wake_flag_o,
    input logic              irq_o,
    input logic              pullup_dp_o,
    input logic              pullup_dm_o
);
    // R3
    addr_zero_after_bus_reset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bus_reset_i |=> (dev_addr_o == '0));
    // R3
    addr_zero_after_disable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !macro_en_i |=> (dev_addr_o == '0));
    // R4
    match_needs_token_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        addr_match_o |-> $past(token_valid_i));
    // R5
    susp_after_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(susp_flag_o) |-> $past(line_idle_i));
    // R7
    wake_after_activity_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(wake_flag_o) |-> !$past(line_idle_i));
    // R8
    flags_exclusive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(susp_flag_o && wake_flag_o));
    // R10
    irq_needs_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> (susp_flag_o || wake_flag_o));
    // R11
    single_pullup_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(pullup_dp_o && pullup_dm_o));
endmodule

bind usb_addr_bus_ctrl usbab_chk #(.ADDR_W(ADDR_W)) i_chk (.*);

// File: tb/test_usb_addr_bus_ctrl.sv
module test_usb_addr_bus_ctrl;
    localparam int AW   = 7;
    localparam int IDLE = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [1:0] wr_sel = '0;
    logic [AW-1:0] wr_data = '0;
    logic bus_reset = 1'b0, macro_en = 1'b1, line_idle = 1'b0, hs_grant = 1'b0;
    logic token_valid = 1'b0;
    logic [AW-1:0] token_addr = '0;
    logic susp, wake, irq, match, frz, hs, dp, dm;
    logic [AW-1:0] dev_addr;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    usb_addr_bus_ctrl #(.ADDR_W(AW), .CLK_MHZ(1), .IDLE_US(IDLE)) i_usb_addr_bus_ctrl (
        .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
        .wr_data_i(wr_data), .bus_reset_i(bus_reset), .macro_en_i(macro_en),
        .line_idle_i(line_idle), .hs_grant_i(hs_grant), .token_valid_i(token_valid),
        .token_addr_i(token_addr), .susp_flag_o(susp), .wake_flag_o(wake), .irq_o(irq),
        .dev_addr_o(dev_addr), .addr_match_o(match), .freeze_clk_o(frz),
        .hs_mode_o(hs), .pullup_dp_o(dp), .pullup_dm_o(dm)
    );

    typedef struct packed {
        logic [AW-1:0] addr;
        logic          en;
        logic [AW-1:0] tok;
        logic          exp_match;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{7'h05, 1'b0, 7'h00, 1'b1},
        '{7'h05, 1'b0, 7'h05, 1'b0},
        '{7'h05, 1'b1, 7'h05, 1'b1},
        '{7'h05, 1'b1, 7'h00, 1'b0},
        '{7'h7F, 1'b1, 7'h7F, 1'b1},
        '{7'h2A, 1'b1, 7'h2B, 1'b0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] sel, input logic [AW-1:0] data);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        // R1 reset state
        chk("R1 dev_addr", dev_addr, 0);
        chk("R1 flags", {susp, wake, irq, match}, 0);
        chk("R1 pullups", {dp, dm}, 0);
        chk("R1 freeze/hs", {frz, hs}, 0);

        // R11 pull-up selection, R12 freeze bit
        wr(2'd1, 7'b0000000);
        chk("R11 full speed", {dp, dm}, 2'b10);
        wr(2'd1, 7'b0001000);
        chk("R11 low speed", {dp, dm}, 2'b01);
        wr(2'd1, 7'b0000100);
        chk("R11 detached", {dp, dm}, 2'b00);
        wr(2'd1, 7'b0000010);
        chk("R12 freeze set", frz, 1);
        wr(2'd1, 7'b0000000);
        chk("R12 freeze clear", frz, 0);

        // R2 / R4 table
        foreach (VECS[i]) begin
            wr(2'd0, VECS[i].addr);
            wr(2'd1, AW'(VECS[i].en));
            chk("R2 effective address", dev_addr, VECS[i].en ? VECS[i].addr : 7'h00);
            token_addr = VECS[i].tok; token_valid = 1'b1;
            step(1);
            token_valid = 1'b0;
            chk("R4 match", match, VECS[i].exp_match);
            step(1);
            chk("R4 single pulse", match, 0);
        end

        // R3 bus reset and disable
        wr(2'd0, 7'h11); wr(2'd1, 7'h01);
        chk("R3 before reset", dev_addr, 7'h11);
        bus_reset = 1'b1; step(1); bus_reset = 1'b0;
        chk("R3 bus reset", dev_addr, 0);
        wr(2'd1, 7'h01);
        chk("R3 stored address cleared", dev_addr, 0);
        wr(2'd0, 7'h22);
        chk("R2 enabled address", dev_addr, 7'h22);
        macro_en = 1'b0; step(1); macro_en = 1'b1;
        chk("R3 disable clears enable", dev_addr, 0);
        wr(2'd1, 7'h01);
        chk("R3 address kept on disable", dev_addr, 7'h22);

        // R6 high speed
        hs_grant = 1'b1; step(1); hs_grant = 1'b0;
        chk("R6 hs set", hs, 1);

        // R5 suspend timing
        line_idle = 1'b1;
        step(IDLE - 1);
        chk("R5 not yet", susp, 0);
        step(1);
        chk("R5 suspend", susp, 1);
        chk("R6 hs cleared", hs, 0);
        wr(2'd3, 7'h01);
        chk("R9 clear suspend", susp, 0);
        step(IDLE + 4);
        chk("R5 once per span", susp, 0);

        // R7 wake
        line_idle = 1'b0; step(1);
        chk("R7 wake", {susp, wake}, 2'b01);

        // R8 mutual clearing
        line_idle = 1'b1; step(IDLE);
        chk("R8 suspend clears wake", {susp, wake}, 2'b10);
        line_idle = 1'b0; step(1);
        chk("R8 wake clears suspend", {susp, wake}, 2'b01);

        // R5 restart
        line_idle = 1'b1; step(10);
        line_idle = 1'b0; step(1);
        line_idle = 1'b1; step(IDLE - 1);
        chk("R5 restart count", susp, 0);
        step(1);
        chk("R5 after restart", susp, 1);

        // R9 event beats clear
        wr(2'd3, 7'h03);
        chk("R9 clear both", {susp, wake}, 2'b00);
        line_idle = 1'b0; step(1);
        wr(2'd3, 7'h02);
        chk("R9 clear wake", wake, 0);
        line_idle = 1'b1; step(IDLE - 1);
        wr(2'd3, 7'h01);
        chk("R9 event wins", susp, 1);

        // R10 interrupt request
        chk("R10 masked", irq, 0);
        wr(2'd2, 7'h01);
        chk("R10 suspend enabled", irq, 1);
        wr(2'd2, 7'h02);
        chk("R10 wake enable only", irq, 0);
        line_idle = 1'b0; step(1);
        chk("R10 wake irq", irq, 1);
        wr(2'd3, 7'h02);
        chk("R10 cleared", irq, 0);

        // R7 wake without suspend
        line_idle = 1'b1; step(3);
        line_idle = 1'b0; step(1);
        chk("R7 wake without suspend", {susp, wake}, 2'b01);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule